// File: doc/BRIEF.md
# GPIO Pin Drive and Sense Resolver

This block resolves, for every pin of a general-purpose I/O port, how the pad behaves given its configuration word, the output latch bit and what the outside world is doing to the pin. It works out whether the output driver is on and at what level. It works out what the input register sees, and whether the internal and external drivers fight. It also produces one port-wide level-detect line, which is the OR of every pin's sense match.

Drive modes differ only in when they connect the driver. Some connect it always. Others connect it only for a high level (open-source style) or only for a low level (open-drain style). Pull resistors set the input of an isolated buffer. They also set both the input and the effective output of a floating pin. A per-pin change strobe tells downstream pad logic when a pin's effective enable or level has moved.

All results are registered. Each one appears on the first rising clock edge after the inputs that cause it.

Top module: `gpio_pad_resolver`

## Requirements
- R1: The configuration word fields are: bit 0 direction (1 = output), bit 1 input-buffer isolate (1 = isolated), bits 3:2 pull select, bits 10:8 drive mode, bits 17:16 sense mode. A pin's `pad_oe` is 1 only when its direction bit is 1 and its drive mode connects the driver. The one exception is the floating-pull case of R5. When `pad_oe` is driven by the latch, `pad_lvl` equals the latch bit. `pad_lvl` also equals the latch bit when the pin is not driven at all.
- R2: Drive modes 0 to 3 always connect the driver. Modes 4 and 5 connect it only when the latch bit is 1. Modes 6 and 7 connect it only when the latch bit is 0.
- R3: With the input buffer isolated and a pull selected, the input bit takes the pull value. This holds even when the pin is driven externally. With the buffer isolated, no pull and no external drive, the input bit holds its value.
- R4: With the buffer connected, no external drive and the output enabled, the input bit follows the latch bit.
- R5: Pull select encoding is 0 none, 1 pull-down (0), 2 none, 3 pull-up (1). With the buffer connected, no external drive, the output not enabled and a pull selected, the pin is driven to the pull value: `pad_oe`=1, `pad_lvl`=pull value and input=pull value. With no pull in this case, the input holds its value.
- R6: When a pin's external-driven flag is 1 and its buffer is not isolated with a pull, the external value is captured into its input bit.
- R7: `short_flag` for a pin is 1 when the buffer is connected, the output is enabled by the latch, the pin is driven externally and the external value differs from the latch bit.
- R8: `detect` is 1 when any externally driven pin with a connected buffer has sense mode 2 and external value 1, or sense mode 3 and external value 0. Sense modes 0 and 1 never detect.
- R9: `chg_stb` for a pin is 1 for one cycle exactly when the new (`pad_oe`, `pad_lvl`) pair differs from the previous registered pair.
- R10: During reset, `pad_oe`, `pad_lvl`, `in_reg`, `short_flag`, `chg_stb` and `detect` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flat | input | NPINS*CFG_W | Per-pin configuration words, pin i at bits [i*CFG_W +: CFG_W] |
| out_latch | input | NPINS | Output latch bit per pin |
| ext_val | input | NPINS | Level driven onto each pin from outside |
| ext_drv | input | NPINS | 1 when the pin is driven from outside |
| pad_oe | output | NPINS | Effective output enable |
| pad_lvl | output | NPINS | Effective output level |
| in_reg | output | NPINS | Input register |
| short_flag | output | NPINS | Internal and external drive disagree |
| chg_stb | output | NPINS | Effective enable or level changed |
| detect | output | 1 | Port-wide level-detect |

## Verification
Every output of this block is due on the first rising edge after a change to the configuration, latch or external inputs. The change strobe rises on that same edge, together with the enable and level it reports, and falls one edge later if nothing else moves. The bench changes inputs one nanosecond after an edge and samples one nanosecond after the next edge, so each check sees exactly one register stage. A strobe check is repeated one cycle later to confirm that the pulse lasts a single cycle.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  localparam int DIR_BIT  = 0;
  localparam int ISO_BIT  = 1;
  localparam int PULL_LO  = 2;
  localparam int DRV_LO   = 8;
  localparam int SNS_LO   = 16;
  localparam int CFG_MINW = 18;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_RSVD = 2'd2,
    PULL_UP   = 2'd3
  } pull_e;

  // Driver connection per drive mode and output level
  function automatic logic drv_connects(input logic [2:0] mode, input logic lvl);
    if (!mode[2]) return 1'b1;
    if (!mode[1]) return lvl;
    return ~lvl;
  endfunction

  function automatic logic pull_active(input logic [1:0] p);
    return (p == PULL_DOWN) || (p == PULL_UP);
  endfunction

  function automatic logic pull_level(input logic [1:0] p);
    return (p == PULL_UP);
  endfunction

  function automatic logic sense_match(input logic [1:0] s, input logic v);
    return ((s == 2'd2) && v) || ((s == 2'd3) && !v);
  endfunction
endpackage

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_res_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             latch,
  input  logic             ext_v,
  input  logic             ext_d,
  input  logic             in_cur,
  output logic             eff_oe,
  output logic             eff_lvl,
  output logic             in_next,
  output logic             short_hit,
  output logic             sense_hit
);
  logic       dir_out;
  logic       iso;
  logic [1:0] pull;
  logic [2:0] mode;
  logic [1:0] sns;
  logic       drv_oe;

  assign dir_out = cfg[DIR_BIT];
  assign iso     = cfg[ISO_BIT];
  assign pull    = cfg[PULL_LO +: 2];
  assign mode    = cfg[DRV_LO +: 3];
  assign sns     = cfg[SNS_LO +: 2];
  assign drv_oe  = dir_out & drv_connects(mode, latch);

  always_comb begin
    eff_oe  = drv_oe;
    eff_lvl = latch;
    in_next = in_cur;
    if (iso) begin
      if (pull_active(pull))  in_next = pull_level(pull);
      else if (ext_d)         in_next = ext_v;
    end else if (ext_d) begin
      in_next = ext_v;
    end else if (drv_oe) begin
      in_next = latch;
    end else if (pull_active(pull)) begin
      eff_oe  = 1'b1;
      eff_lvl = pull_level(pull);
      in_next = pull_level(pull);
    end
  end

  assign short_hit = ~iso & drv_oe & ext_d & (ext_v ^ latch);
  assign sense_hit = ~iso & ext_d & sense_match(sns, ext_v);
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic eff_oe,
  input  logic eff_lvl,
  input  logic in_next,
  input  logic short_hit,
  output logic oe_q,
  output logic lvl_q,
  output logic in_q,
  output logic short_q,
  output logic stb_q
);
  logic pair_moved;
  assign pair_moved = (eff_oe != oe_q) || (eff_lvl != lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      lvl_q   <= 1'b0;
      in_q    <= 1'b0;
      short_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      oe_q    <= eff_oe;
      lvl_q   <= eff_lvl;
      in_q    <= in_next;
      short_q <= short_hit;
      stb_q   <= pair_moved;
    end
  end
endmodule

// File: rtl/gpio_pad_resolver.sv
module gpio_pad_resolver
  import gpio_res_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int CFG_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS*CFG_W-1:0] cfg_flat,
  input  logic [NPINS-1:0]       out_latch,
  input  logic [NPINS-1:0]       ext_val,
  input  logic [NPINS-1:0]       ext_drv,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       pad_lvl,
  output logic [NPINS-1:0]       in_reg,
  output logic [NPINS-1:0]       short_flag,
  output logic [NPINS-1:0]       chg_stb,
  output logic                   detect
);
  logic [NPINS-1:0] eff_oe_w, eff_lvl_w, in_next_w, short_w, sense_w;
  logic             detect_any;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_resolve #(.CFG_W(CFG_W)) u_res (
      .cfg       (cfg_flat[i*CFG_W +: CFG_W]),
      .latch     (out_latch[i]),
      .ext_v     (ext_val[i]),
      .ext_d     (ext_drv[i]),
      .in_cur    (in_reg[i]),
      .eff_oe    (eff_oe_w[i]),
      .eff_lvl   (eff_lvl_w[i]),
      .in_next   (in_next_w[i]),
      .short_hit (short_w[i]),
      .sense_hit (sense_w[i])
    );
    gpio_pin_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .eff_oe    (eff_oe_w[i]),
      .eff_lvl   (eff_lvl_w[i]),
      .in_next   (in_next_w[i]),
      .short_hit (short_w[i]),
      .oe_q      (pad_oe[i]),
      .lvl_q     (pad_lvl[i]),
      .in_q      (in_reg[i]),
      .short_q   (short_flag[i]),
      .stb_q     (chg_stb[i])
    );
  end

  assign detect_any = |sense_w;

  always_ff @(posedge clk) begin
    if (!rst_n) detect <= 1'b0;
    else        detect <= detect_any;
  end
endmodule

// File: rtl/gpio_pad_resolver_chk.sv
module gpio_pad_resolver_chk #(
  parameter int NPINS = 32,
  parameter int CFG_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPINS*CFG_W-1:0] cfg_flat,
  input logic [NPINS-1:0]       ext_drv,
  input logic [NPINS-1:0]       pad_oe,
  input logic [NPINS-1:0]       pad_lvl,
  input logic [NPINS-1:0]       in_reg,
  input logic [NPINS-1:0]       short_flag,
  input logic [NPINS-1:0]       chg_stb,
  input logic                   detect
);
  logic             seen;
  logic [NPINS-1:0] dir_v, pulled_v, iso_up_v;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      dir_v[i]    = cfg_flat[i*CFG_W];
      pulled_v[i] = cfg_flat[i*CFG_W + 2];
      iso_up_v[i] = cfg_flat[i*CFG_W + 1] & (cfg_flat[i*CFG_W + 3 -: 2] == 2'd3);
    end
  end

  AST_STB_MATCHES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (chg_stb == ((pad_oe ^ $past(pad_oe)) | (pad_lvl ^ $past(pad_lvl))))); // R9

  AST_OE_NEEDS_DIR_OR_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((pad_oe & ~($past(dir_v) | $past(pulled_v))) == '0)); // R1

  AST_ISO_PULLUP_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (($past(iso_up_v) & ~in_reg) == '0)); // R3

  AST_SHORT_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((short_flag & ~$past(ext_drv)) == '0)); // R7

  AST_DETECT_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && detect) |-> $past(|ext_drv)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (chg_stb == '0 || seen))); // R10
endmodule

bind gpio_pad_resolver gpio_pad_resolver_chk #(.NPINS(NPINS), .CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_flat   (cfg_flat),
  .ext_drv    (ext_drv),
  .pad_oe     (pad_oe),
  .pad_lvl    (pad_lvl),
  .in_reg     (in_reg),
  .short_flag (short_flag),
  .chg_stb    (chg_stb),
  .detect     (detect)
);

// File: tb/tb_gpio_pad_resolver.sv
module tb_gpio_pad_resolver;
  localparam int NP = 32;
  localparam int CW = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP*CW-1:0] cfg_flat;
  logic [NP-1:0]   out_latch, ext_val, ext_drv;
  logic [NP-1:0]   pad_oe, pad_lvl, in_reg, short_flag, chg_stb;
  logic            detect;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_pad_resolver #(.NPINS(NP), .CFG_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat), .out_latch(out_latch),
    .ext_val(ext_val), .ext_drv(ext_drv), .pad_oe(pad_oe), .pad_lvl(pad_lvl),
    .in_reg(in_reg), .short_flag(short_flag), .chg_stb(chg_stb), .detect(detect)
  );

  function automatic logic [31:0] mk_cfg(input logic dir, input logic iso,
      input logic [1:0] pull, input logic [2:0] drv, input logic [1:0] sns);
    return {14'b0, sns, 5'b0, drv, 4'b0, pull, iso, dir};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int p, input logic [31:0] c);
    cfg_flat[p*CW +: CW] = c;
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic defaults;
    for (int p = 0; p < NP; p++) set_cfg(p, mk_cfg(0, 1, 0, 0, 0));
    out_latch = '0; ext_val = '0; ext_drv = '0;
    tick; tick;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    for (int p = 0; p < NP; p++) set_cfg(p, mk_cfg(1, 0, 3, 0, 2));
    out_latch = '1; ext_val = '1; ext_drv = '1;
    tick; tick;
    chk("R10 oe", pad_oe, '0);
    chk("R10 lvl", pad_lvl, '0);
    chk("R10 in", in_reg, '0);
    chk("R10 short", short_flag, '0);
    chk("R10 stb", chg_stb, '0);
    chk("R10 detect", {31'b0, detect}, 0);
    rst_n = 1'b1;
    defaults;
  endtask

  task automatic t_drive_modes;
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 2; l++) begin
        logic e;
        e = (m < 4) ? 1'b1 : (m < 6) ? (l == 1) : (l == 0);
        set_cfg(0, mk_cfg(1, 0, 0, 3'(m), 0));
        out_latch[0] = 1'(l);
        tick;
        chk("R2 mode oe", {31'b0, pad_oe[0]}, {31'b0, e});
        chk("R1 lvl", {31'b0, pad_lvl[0]}, 32'(l));
      end
    end
    set_cfg(0, mk_cfg(0, 0, 0, 0, 0));
    out_latch[0] = 1'b1;
    tick;
    chk("R1 dir0 oe", {31'b0, pad_oe[0]}, 0);
    defaults;
  endtask

  task automatic t_iso_pull;
    set_cfg(3, mk_cfg(0, 1, 3, 0, 0));
    ext_drv[3] = 1'b1; ext_val[3] = 1'b0;
    tick;
    chk("R3 iso pullup over ext", {31'b0, in_reg[3]}, 1);
    ext_drv[3] = 1'b0;
    set_cfg(3, mk_cfg(0, 1, 0, 0, 0));
    tick;
    chk("R3 iso no pull holds", {31'b0, in_reg[3]}, 1);
    set_cfg(3, mk_cfg(0, 1, 1, 0, 0));
    tick;
    chk("R3 iso pulldown", {31'b0, in_reg[3]}, 0);
    defaults;
  endtask

  task automatic t_follow;
    set_cfg(4, mk_cfg(1, 0, 0, 0, 0));
    out_latch[4] = 1'b1;
    tick;
    chk("R4 follow 1", {31'b0, in_reg[4]}, 1);
    out_latch[4] = 1'b0;
    tick;
    chk("R4 follow 0", {31'b0, in_reg[4]}, 0);
    defaults;
  endtask

  task automatic t_float_pull;
    set_cfg(2, mk_cfg(0, 0, 3, 0, 0));
    tick;
    chk("R5 pullup oe", {31'b0, pad_oe[2]}, 1);
    chk("R5 pullup lvl", {31'b0, pad_lvl[2]}, 1);
    chk("R5 pullup in", {31'b0, in_reg[2]}, 1);
    set_cfg(2, mk_cfg(0, 0, 2, 0, 0));
    tick;
    chk("R5 code2 oe", {31'b0, pad_oe[2]}, 0);
    chk("R5 code2 in holds", {31'b0, in_reg[2]}, 1);
    set_cfg(2, mk_cfg(0, 0, 1, 0, 0));
    tick;
    chk("R5 pulldown oe", {31'b0, pad_oe[2]}, 1);
    chk("R5 pulldown in", {31'b0, in_reg[2]}, 0);
    defaults;
  endtask

  task automatic t_ext;
    set_cfg(6, mk_cfg(0, 0, 1, 0, 0));
    ext_drv[6] = 1'b1; ext_val[6] = 1'b1;
    tick;
    chk("R6 ext 1 over pulldown", {31'b0, in_reg[6]}, 1);
    chk("R6 ext no pull drive", {31'b0, pad_oe[6]}, 0);
    ext_val[6] = 1'b0;
    tick;
    chk("R6 ext 0", {31'b0, in_reg[6]}, 0);
    defaults;
  endtask

  task automatic t_short;
    set_cfg(7, mk_cfg(1, 0, 0, 0, 0));
    out_latch[7] = 1'b1; ext_drv[7] = 1'b1; ext_val[7] = 1'b0;
    tick;
    chk("R7 short", short_flag, 32'h0000_0080);
    ext_val[7] = 1'b1;
    tick;
    chk("R7 agree", short_flag, '0);
    set_cfg(7, mk_cfg(1, 0, 0, 4, 0));
    out_latch[7] = 1'b0;
    tick;
    chk("R7 driver off", short_flag, '0);
    defaults;
  endtask

  task automatic t_detect;
    set_cfg(9, mk_cfg(0, 0, 0, 0, 2));
    ext_drv[9] = 1'b1; ext_val[9] = 1'b1;
    tick;
    chk("R8 sense2 hi", {31'b0, detect}, 1);
    set_cfg(9, mk_cfg(0, 0, 0, 0, 3));
    tick;
    chk("R8 sense3 hi", {31'b0, detect}, 0);
    ext_val[9] = 1'b0;
    tick;
    chk("R8 sense3 lo", {31'b0, detect}, 1);
    set_cfg(9, mk_cfg(0, 1, 0, 0, 3));
    tick;
    chk("R8 iso no detect", {31'b0, detect}, 0);
    set_cfg(9, mk_cfg(0, 0, 0, 0, 3));
    ext_drv[9] = 1'b0;
    tick;
    chk("R8 not ext no detect", {31'b0, detect}, 0);
    set_cfg(9, mk_cfg(0, 0, 0, 0, 1));
    ext_drv[9] = 1'b1;
    tick;
    chk("R8 sense1 no detect", {31'b0, detect}, 0);
    defaults;
  endtask

  task automatic t_strobe;
    set_cfg(5, mk_cfg(0, 0, 0, 0, 0));
    tick;
    tick;
    chk("R9 idle", chg_stb, '0);
    out_latch[5] = 1'b1;
    tick;
    chk("R9 level change", chg_stb, 32'h0000_0020);
    chk("R9 lvl", pad_lvl, 32'h0000_0020);
    tick;
    chk("R9 one cycle", chg_stb, '0);
    set_cfg(5, mk_cfg(1, 0, 0, 0, 0));
    tick;
    chk("R9 enable change", chg_stb, 32'h0000_0020);
    defaults;
  endtask

  initial begin
    cfg_flat = '0; out_latch = '0; ext_val = '0; ext_drv = '0; rst_n = 1'b0;
    #2;
    t_reset;
    t_drive_modes;
    t_iso_pull;
    t_follow;
    t_float_pull;
    t_ext;
    t_short;
    t_detect;
    t_strobe;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule